// File: doc/BRIEF.md
# Tile Ownership Filter

This block sits in front of the rasterizer of one renderer in a group of one, two or four renderers that draw the same frame together. The screen is cut into square tiles of 16, 32 or 64 pixels. Each renderer owns a fixed, interleaved share of those tiles. For every incoming primitive bounding box, the filter works out which of this renderer's tiles the box covers. It then hands those tile coordinates to the rasterizer one at a time, in row-major order.

A box that covers none of the owned tiles is consumed at once and produces no output. A single-cycle reject strobe marks such a box. The box corners are first clamped to the configured screen size. They are then shifted down to tile units. The configuration inputs (tile size, renderer count, renderer index, screen size) are captured together with each box. Changing them while a box is being walked has no effect on that box.

Top module: `tile_own_filter`

## Requirements
- R1: Tile coordinates equal the clamped pixel coordinate shifted right by 4, 5 or 6 for `tile_sel_i` values 0, 1 and 2. The value 3 selects a shift of 6.
- R2: Before conversion, each x corner is limited to `scr_w_i - 1` and each y corner is limited to `scr_h_i - 1`.
- R3: Ownership depends on `chip_cnt_i`. With value 0, all tiles are owned. With value 1, tile (tx, ty) is owned when bit 0 of tx+ty equals bit 0 of `chip_idx_i`. With values 2 and 3, a tile is owned when bit 0 of tx equals `chip_idx_i[0]` and bit 0 of ty equals `chip_idx_i[1]`.
- R4: For an accepted box, the block emits every owned tile whose coordinates lie within the converted box range. Each such tile appears exactly once and no other tile appears.
- R5: Emitted tiles come in row-major order: ascending y, and ascending x within a row.
- R6: A tile is offered in the cycle after acceptance or after the previous tile was taken. While `tile_ready_i` is low, `tile_valid_o`, `tile_x_o` and `tile_y_o` hold.
- R7: `tile_last_o` is high with the final tile of a box and low with every other tile.
- R8: A box with no owned tile raises `reject_o` for exactly the cycle after its acceptance, and `tile_valid_o` stays low for it.
- R9: `bb_ready_o` is high only while no box is being walked. It is high again in the cycle after the final tile is taken, so boxes can follow back to back.
- R10: Configuration inputs are sampled when a box is accepted. Changing them during the walk does not alter that box's tiles.
- R11: During and right after reset, `bb_ready_o` is 1, `tile_valid_o` is 0 and `reject_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tile_sel_i | input | 2 | Tile size select (0:16, 1:32, 2/3:64 pixels) |
| chip_cnt_i | input | 2 | Renderer count select (0:one, 1:two, 2/3:four) |
| chip_idx_i | input | 2 | Index of this renderer |
| scr_w_i | input | COORD_W | Screen width in pixels (at least 1) |
| scr_h_i | input | COORD_W | Screen height in pixels (at least 1) |
| bb_x0_i | input | COORD_W | Box left pixel (inclusive) |
| bb_y0_i | input | COORD_W | Box top pixel (inclusive) |
| bb_x1_i | input | COORD_W | Box right pixel (inclusive) |
| bb_y1_i | input | COORD_W | Box bottom pixel (inclusive) |
| bb_valid_i | input | 1 | Box offered |
| bb_ready_o | output | 1 | Block can take a box |
| tile_x_o | output | COORD_W-4 | Tile column |
| tile_y_o | output | COORD_W-4 | Tile row |
| tile_last_o | output | 1 | Final tile of the current box |
| tile_valid_o | output | 1 | Tile offered |
| tile_ready_i | input | 1 | Rasterizer takes the tile |
| reject_o | output | 1 | Box dropped, no owned tile |

## Verification
The assertions assume a well-formed box: x0 not above x1 and y0 not above y1. They also assume screen dimensions of at least one pixel, so that clamping keeps the corner order intact.

Every vector in the stimulus table is written with ordered corners. The screen is fixed at 640 by 480. The one out-of-screen box exceeds the screen on its far corner only, so it still clamps to a non-empty range.

The expected tile lists come from a brute-force scan of every tile in the box inside the bench.

// File: rtl/tile_own_pkg.sv
package tile_own_pkg;

  typedef enum logic [1:0] {
    MODE_ONE  = 2'd0,
    MODE_TWO  = 2'd1,
    MODE_FOUR = 2'd2
  } chip_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_EMIT = 1'b1
  } walk_st_e;

  function automatic chip_mode_e decode_mode(input logic [1:0] sel);
    case (sel)
      2'd0:    return MODE_ONE;
      2'd1:    return MODE_TWO;
      default: return MODE_FOUR;
    endcase
  endfunction

  function automatic logic [2:0] decode_shift(input logic [1:0] sel);
    case (sel)
      2'd0:    return 3'd4;
      2'd1:    return 3'd5;
      default: return 3'd6;
    endcase
  endfunction

endpackage

// File: rtl/tile_own_conv.sv
module tile_own_conv #(
  parameter int COORD_W = 12
) (
  input  logic [2:0]         shift_i,
  input  logic [COORD_W-1:0] scr_w_i,
  input  logic [COORD_W-1:0] scr_h_i,
  input  logic [COORD_W-1:0] px_i [4],  // x0, y0, x1, y1
  output logic [COORD_W-1:0] tc_o [4]
);

  logic [COORD_W-1:0] lim_x, lim_y;

  assign lim_x = scr_w_i - COORD_W'(1);
  assign lim_y = scr_h_i - COORD_W'(1);

  for (genvar g = 0; g < 4; g++) begin : g_corner
    logic [COORD_W-1:0] lim, clmp;
    assign lim     = (g % 2 == 0) ? lim_x : lim_y;
    assign clmp    = (px_i[g] > lim) ? lim : px_i[g];
    assign tc_o[g] = clmp >> shift_i;
  end

endmodule

// File: rtl/tile_own_rowsel.sv
module tile_own_rowsel
  import tile_own_pkg::*;
#(
  parameter int TCW = 12
) (
  input  chip_mode_e     mode_i,
  input  logic           own_bit_i,
  input  logic           ypar_i,
  input  logic [TCW-1:0] tx0_i,
  input  logic [TCW-1:0] tx1_i,
  output logic [TCW-1:0] fx_o,
  output logic           ok_o
);

  logic want;

  // parity of the first owned column in this row
  always_comb begin
    case (mode_i)
      MODE_TWO:  want = own_bit_i ^ ypar_i;
      MODE_FOUR: want = own_bit_i;
      default:   want = tx0_i[0];
    endcase
  end

  assign fx_o = tx0_i + TCW'(tx0_i[0] != want);
  assign ok_o = (fx_o <= tx1_i);

endmodule

// File: rtl/tile_own_filter.sv
module tile_own_filter
  import tile_own_pkg::*;
#(
  parameter int COORD_W = 12,
  localparam int TW     = COORD_W - 4,
  localparam int TCW    = COORD_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         tile_sel_i,
  input  logic [1:0]         chip_cnt_i,
  input  logic [1:0]         chip_idx_i,
  input  logic [COORD_W-1:0] scr_w_i,
  input  logic [COORD_W-1:0] scr_h_i,
  input  logic [COORD_W-1:0] bb_x0_i,
  input  logic [COORD_W-1:0] bb_y0_i,
  input  logic [COORD_W-1:0] bb_x1_i,
  input  logic [COORD_W-1:0] bb_y1_i,
  input  logic               bb_valid_i,
  output logic               bb_ready_o,
  output logic [TW-1:0]      tile_x_o,
  output logic [TW-1:0]      tile_y_o,
  output logic               tile_last_o,
  output logic               tile_valid_o,
  input  logic               tile_ready_i,
  output logic               reject_o
);

  walk_st_e       state_q;
  chip_mode_e     mode_q;
  logic [1:0]     idx_q;
  logic [TCW-1:0] tx0_q, tx1_q, ty0_q, ty1_q, x_q, y_q;
  logic           reject_q;

  logic               idle, accept;
  logic [COORD_W-1:0] px [4];
  logic [TCW-1:0]     in_tc [4];
  logic [2:0]         in_shift;
  chip_mode_e         in_mode, cur_mode;
  logic               cur_own;
  logic [TCW-1:0]     cur_tx0, cur_tx1, cur_ty1, start_y;
  logic [TCW-1:0]     row_y [2];
  logic [TCW-1:0]     row_fx [2];
  logic               row_ok [2];
  logic [TCW-1:0]     nrow_y, nrow_fx, step_x;
  logic               nrow_ok, step_ok;

  assign px[0]    = bb_x0_i;
  assign px[1]    = bb_y0_i;
  assign px[2]    = bb_x1_i;
  assign px[3]    = bb_y1_i;
  assign in_shift = decode_shift(tile_sel_i);
  assign in_mode  = decode_mode(chip_cnt_i);

  tile_own_conv #(.COORD_W(COORD_W)) u_conv (
    .shift_i (in_shift),
    .scr_w_i (scr_w_i),
    .scr_h_i (scr_h_i),
    .px_i    (px),
    .tc_o    (in_tc)
  );

  assign idle   = (state_q == ST_IDLE);
  assign accept = idle && bb_valid_i;

  // live inputs while idle, captured copy while walking
  assign cur_mode = idle ? in_mode       : mode_q;
  assign cur_own  = idle ? chip_idx_i[0] : idx_q[0];
  assign cur_tx0  = idle ? in_tc[0]      : tx0_q;
  assign cur_tx1  = idle ? in_tc[2]      : tx1_q;
  assign cur_ty1  = idle ? in_tc[3]      : ty1_q;

  assign start_y = in_tc[1] + TCW'((in_mode == MODE_FOUR) && (in_tc[1][0] != chip_idx_i[1]));

  // candidate 0 is the natural next row, candidate 1 skips one more
  assign row_y[0] = idle ? start_y
                         : y_q + ((mode_q == MODE_FOUR) ? TCW'(2) : TCW'(1));
  assign row_y[1] = idle ? start_y + TCW'(1) : y_q + TCW'(2);

  for (genvar g = 0; g < 2; g++) begin : g_row
    tile_own_rowsel #(.TCW(TCW)) u_row (
      .mode_i    (cur_mode),
      .own_bit_i (cur_own),
      .ypar_i    (row_y[g][0]),
      .tx0_i     (cur_tx0),
      .tx1_i     (cur_tx1),
      .fx_o      (row_fx[g]),
      .ok_o      (row_ok[g])
    );
  end

  assign nrow_y  = row_ok[0] ? row_y[0]  : row_y[1];
  assign nrow_fx = row_ok[0] ? row_fx[0] : row_fx[1];
  assign nrow_ok = (row_ok[0] || row_ok[1]) && (nrow_y <= cur_ty1);

  assign step_x  = x_q + ((mode_q == MODE_ONE) ? TCW'(1) : TCW'(2));
  assign step_ok = (step_x <= tx1_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      mode_q   <= MODE_ONE;
      idx_q    <= '0;
      tx0_q    <= '0;
      tx1_q    <= '0;
      ty0_q    <= '0;
      ty1_q    <= '0;
      x_q      <= '0;
      y_q      <= '0;
      reject_q <= 1'b0;
    end else begin
      reject_q <= accept && !nrow_ok;
      case (state_q)
        ST_IDLE: begin
          if (accept && nrow_ok) begin
            state_q <= ST_EMIT;
            mode_q  <= in_mode;
            idx_q   <= chip_idx_i;
            tx0_q   <= in_tc[0];
            ty0_q   <= in_tc[1];
            tx1_q   <= in_tc[2];
            ty1_q   <= in_tc[3];
            x_q     <= nrow_fx;
            y_q     <= nrow_y;
          end
        end
        default: begin
          if (tile_ready_i) begin
            if (step_ok) begin
              x_q <= step_x;
            end else if (nrow_ok) begin
              x_q <= nrow_fx;
              y_q <= nrow_y;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
      endcase
    end
  end

  assign bb_ready_o   = idle;
  assign tile_valid_o = !idle;
  assign tile_x_o     = x_q[TW-1:0];
  assign tile_y_o     = y_q[TW-1:0];
  assign tile_last_o  = !idle && !step_ok && !nrow_ok;
  assign reject_o     = reject_q;

  AST_REJ_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_o |-> !tile_valid_o);  // R8

  AST_REJ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_o |-> $past(bb_valid_i && bb_ready_o));  // R8

  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tile_valid_o && !tile_ready_i |=> tile_valid_o && $stable(tile_x_o) && $stable(tile_y_o));  // R6

  AST_OWNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tile_valid_o |-> (mode_q == MODE_ONE)
                  || (mode_q == MODE_TWO && ((x_q[0] ^ y_q[0]) == idx_q[0]))
                  || (mode_q == MODE_FOUR && x_q[0] == idx_q[0] && y_q[0] == idx_q[1]));  // R3

  AST_IN_BOX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tile_valid_o |-> x_q >= tx0_q && x_q <= tx1_q && y_q >= ty0_q && y_q <= ty1_q);  // R4

  AST_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tile_valid_o && tile_ready_i && !tile_last_o |=>
      tile_valid_o && (y_q > $past(y_q) || (y_q == $past(y_q) && x_q > $past(x_q))));  // R5

  AST_LAST_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tile_valid_o && tile_ready_i && tile_last_o |=> bb_ready_o);  // R9

  AST_MID_CONT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tile_valid_o && tile_ready_i && !tile_last_o |=> !bb_ready_o);  // R7

endmodule

// File: tb/tile_own_filter_tb_top.sv
`timescale 1ns/1ps
module tile_own_filter_tb_top;

  localparam int COORD_W = 12;
  localparam int TW      = COORD_W - 4;
  localparam int NV      = 10;
  localparam int SCR_W   = 640;
  localparam int SCR_H   = 480;

  // tile_sel, chip_cnt, chip_idx, box, expected tile count, stall pattern
  localparam int V_TS [NV]  = '{0, 0, 1, 2, 0, 0, 0, 1, 0, 3};
  localparam int V_CC [NV]  = '{0, 1, 2, 2, 1, 0, 2, 1, 3, 0};
  localparam int V_ID [NV]  = '{0, 1, 3, 0, 0, 0, 2, 0, 1, 0};
  localparam int V_X0 [NV]  = '{0, 0, 0, 70, 16, 600, 0, 32, 16, 0};
  localparam int V_Y0 [NV]  = '{0, 0, 0, 70, 0, 470, 0, 32, 0, 0};
  localparam int V_X1 [NV]  = '{31, 47, 127, 100, 31, 4000, 15, 63, 47, 127};
  localparam int V_Y1 [NV]  = '{15, 31, 127, 100, 63, 4000, 15, 63, 15, 63};
  localparam int V_EXP [NV] = '{2, 3, 4, 0, 2, 3, 0, 1, 1, 2};
  localparam int V_STL [NV] = '{0, 0, 1, 0, 1, 0, 0, 0, 0, 0};

  logic clk = 1'b0;
  logic rst_ni;
  logic [1:0] tile_sel_i, chip_cnt_i, chip_idx_i;
  logic [COORD_W-1:0] scr_w_i, scr_h_i, bb_x0_i, bb_y0_i, bb_x1_i, bb_y1_i;
  logic bb_valid_i, bb_ready_o, tile_last_o, tile_valid_o, tile_ready_i, reject_o;
  logic [TW-1:0] tile_x_o, tile_y_o;

  int errors = 0;
  int checks = 0;
  int cyc    = 0;
  bit done   = 1'b0;
  int exp_x [64];
  int exp_y [64];

  always #2 clk = ~clk;

  tile_own_filter #(.COORD_W(COORD_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .tile_sel_i(tile_sel_i), .chip_cnt_i(chip_cnt_i), .chip_idx_i(chip_idx_i),
    .scr_w_i(scr_w_i), .scr_h_i(scr_h_i),
    .bb_x0_i(bb_x0_i), .bb_y0_i(bb_y0_i), .bb_x1_i(bb_x1_i), .bb_y1_i(bb_y1_i),
    .bb_valid_i(bb_valid_i), .bb_ready_o(bb_ready_o),
    .tile_x_o(tile_x_o), .tile_y_o(tile_y_o), .tile_last_o(tile_last_o),
    .tile_valid_o(tile_valid_o), .tile_ready_i(tile_ready_i), .reject_o(reject_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // brute-force reference: R1 shift, R2 clamp, R3 ownership, R4/R5 scan order
  task automatic model(input int v, output int n);
    int sh, x0, y0, x1, y1;
    sh = (V_TS[v] == 0) ? 4 : (V_TS[v] == 1) ? 5 : 6;
    x0 = (V_X0[v] > SCR_W - 1) ? SCR_W - 1 : V_X0[v];
    y0 = (V_Y0[v] > SCR_H - 1) ? SCR_H - 1 : V_Y0[v];
    x1 = (V_X1[v] > SCR_W - 1) ? SCR_W - 1 : V_X1[v];
    y1 = (V_Y1[v] > SCR_H - 1) ? SCR_H - 1 : V_Y1[v];
    n = 0;
    for (int ty = (y0 >> sh); ty <= (y1 >> sh); ty++) begin
      for (int tx = (x0 >> sh); tx <= (x1 >> sh); tx++) begin
        bit own;
        if (V_CC[v] == 0) own = 1'b1;
        else if (V_CC[v] == 1) own = (((tx + ty) % 2) == (V_ID[v] % 2));
        else own = ((tx % 2) == (V_ID[v] % 2)) && ((ty % 2) == (V_ID[v] / 2));
        if (own && n < 64) begin
          exp_x[n] = tx;
          exp_y[n] = ty;
          n++;
        end
      end
    end
  endtask

  task automatic run_vec(input int v);
    int n, k;
    model(v, n);
    chk(n == V_EXP[v], "R4 table", n, V_EXP[v]);
    @(negedge clk);
    chk(bb_ready_o == 1'b1, "R9 ready before box", int'(bb_ready_o), 1);
    tile_sel_i   = 2'(V_TS[v]);
    chip_cnt_i   = 2'(V_CC[v]);
    chip_idx_i   = 2'(V_ID[v]);
    bb_x0_i      = COORD_W'(V_X0[v]);
    bb_y0_i      = COORD_W'(V_Y0[v]);
    bb_x1_i      = COORD_W'(V_X1[v]);
    bb_y1_i      = COORD_W'(V_Y1[v]);
    bb_valid_i   = 1'b1;
    tile_ready_i = (V_STL[v] != 0) ? 1'b0 : 1'b1;
    @(negedge clk);
    bb_valid_i = 1'b0;
    if (n == 0) begin
      chk(reject_o == 1'b1, "R8 reject pulse", int'(reject_o), 1);
      chk(tile_valid_o == 1'b0, "R8 no tile", int'(tile_valid_o), 0);
      @(negedge clk);
      chk(reject_o == 1'b0, "R8 pulse width", int'(reject_o), 0);
      chk(tile_valid_o == 1'b0, "R8 still no tile", int'(tile_valid_o), 0);
    end else begin
      chk(reject_o == 1'b0, "R8 no reject", int'(reject_o), 0);
      k = 0;
      while (k < n && cyc < 50000) begin
        if (V_STL[v] != 0) tile_ready_i = ~tile_ready_i;
        if (!tile_valid_o) begin
          chk(1'b0, "R6 valid dropped", 0, 1);
          break;
        end
        chk(int'(tile_x_o) == exp_x[k], "R4/R5 tile x", int'(tile_x_o), exp_x[k]);
        chk(int'(tile_y_o) == exp_y[k], "R4/R5 tile y", int'(tile_y_o), exp_y[k]);
        chk(bb_ready_o == 1'b0, "R9 busy", int'(bb_ready_o), 0);
        if (tile_ready_i) begin
          chk(tile_last_o == (k == n - 1), "R7 last flag", int'(tile_last_o), int'(k == n - 1));
          if (V_STL[v] != 0 && k == 0) begin
            // R10: disturb configuration mid-walk
            tile_sel_i = 2'd0;
            chip_cnt_i = 2'd0;
            chip_idx_i = 2'd0;
            scr_w_i    = COORD_W'(20);
            scr_h_i    = COORD_W'(20);
          end
          k++;
        end
        @(negedge clk);
      end
      chk(tile_valid_o == 1'b0, "R9 walk ended", int'(tile_valid_o), 0);
      chk(bb_ready_o == 1'b1, "R9 ready again", int'(bb_ready_o), 1);
      chk(k == n, "R4 tile count", k, n);
      tile_ready_i = 1'b1;
      scr_w_i      = COORD_W'(SCR_W);
      scr_h_i      = COORD_W'(SCR_H);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 60000 && !done) begin
      errors++;
      $display("FAIL R9 watchdog act=%0d exp=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    rst_ni       = 1'b0;
    tile_sel_i   = '0;
    chip_cnt_i   = '0;
    chip_idx_i   = '0;
    scr_w_i      = COORD_W'(SCR_W);
    scr_h_i      = COORD_W'(SCR_H);
    bb_x0_i      = '0;
    bb_y0_i      = '0;
    bb_x1_i      = '0;
    bb_y1_i      = '0;
    bb_valid_i   = 1'b0;
    tile_ready_i = 1'b1;
    repeat (3) @(negedge clk);
    chk(bb_ready_o == 1'b1, "R11 ready in reset", int'(bb_ready_o), 1);
    chk(tile_valid_o == 1'b0, "R11 valid in reset", int'(tile_valid_o), 0);
    chk(reject_o == 1'b0, "R11 reject in reset", int'(reject_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(bb_ready_o == 1'b1 && tile_valid_o == 1'b0 && reject_o == 1'b0,
        "R11 after reset", int'(tile_valid_o), 0);

    for (int v = 0; v < NV; v++) run_vec(v);

    // R9: reject followed immediately by a walking box
    run_vec(6);
    run_vec(1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule